// File: doc/BRIEF.md
# Request-Driven Clock Stop Gating

This block sits on a set of free-running clock outputs and decides, channel by channel, when each one may toggle. It runs in the domain of the clock it gates. Each channel can be halted and restarted by its own active-low request pin, by a global hardware stop input, or by a software stop control bit. All control settings arrive as register vectors. For every channel it drives a true leg, a complement leg and an output-enable. Because the gate is only ever changed while the clock is low, no shortened pulse ever reaches an output.

Request pins are asynchronous. They pass through a synchroniser and a two-edge stability filter before they can act, so a glitch shorter than the filter window is ignored. A channel that is halted parks with both legs low. A per-channel drive-mode bit decides whether a parked channel stays driven or drops its output-enable. A per-channel output-enable bit overrides everything and tri-states the channel at once.

Top module: `clk_stop_gate`

## Requirements
- R1: A change on `req_n[i]` is accepted only after it has held one level across two consecutive rising edges of `clk` after synchronisation. A level held for a single clock period never stops the channel.
- R2: With `req_en[i]`=1, an accepted high level on `req_n[i]` halts channel i after its next transition. While halted, `clk_t[i]` is 0 in every high phase and `clk_c[i]` is 0 in every low phase.
- R3: When accepted requests return low, every halted channel resumes 2 to 6 clock periods after the pins change (5 in this design), and all of them resume on the same cycle.
- R4: With `req_en[i]`=0, `req_n[i]` has no effect and channel i keeps toggling.
- R5: While `stop_n`=0, every channel with `stoppable[i]`=1 halts. Channels with `stoppable[i]`=0 keep toggling.
- R6: After `stop_n` returns high, the halted channels produce their first high phase within two clock periods, and all of them do so on the same cycle.
- R7: `sw_run`=0 halts the stoppable channels in the same way as `stop_n`=0, and `sw_run`=1 resumes them.
- R8: While channel i is halted, `drive_tri[i]`=1 forces `oe[i]`=0 and `drive_tri[i]`=0 keeps `oe[i]`=1.
- R9: `oe_cfg[i]`=0 forces `oe[i]`=0 with no clock delay, whatever the channel's stop state.
- R10: `clk_t` is never high while `clk` is low, so no runt high pulse appears on a stop or a restart.
- R11: After reset every channel toggles, and `oe` equals `oe_cfg`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock being gated; also the block's domain |
| rst | input | 1 | Synchronous active-high reset |
| req_n | input | N_CH | Asynchronous per-channel requests, low = run, high = stop |
| req_en | input | N_CH | Register bits: 1 lets req_n[i] control channel i (reset value 0) |
| stoppable | input | N_CH | Register bits: 1 means channel i obeys the global stops |
| drive_tri | input | N_CH | Register bits: 1 = tri-state while halted, 0 = driven low |
| oe_cfg | input | N_CH | Register bits: channel output enable |
| stop_n | input | 1 | Global hardware stop, active low, synchronous to clk |
| sw_run | input | 1 | Software stop bit, 0 = stop, 1 = run |
| clk_t | output | N_CH | Gated true legs |
| clk_c | output | N_CH | Gated complement legs |
| oe | output | N_CH | Per-channel output enables |

## Verification
The assertions assume that the register vectors and `stop_n` change only shortly after a rising edge, never near a falling edge. The free-running check looks one falling edge back at the configuration that set the gate. The bench drives every input two time units after a rising edge and samples outputs two units into each phase. The request pins are treated as asynchronous in the design, but the bench also drives them at that same offset. Resume latencies can therefore be stated as exact cycle counts and compared for equality across channels.

// File: rtl/csg_pkg.sv
package csg_pkg;
  typedef struct packed {
    logic req_en;
    logic stoppable;
    logic drive_tri;
    logic oe_en;
  } csg_cfg_t;
endpackage

// File: rtl/csg_req_filter.sv
module csg_req_filter #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic req_async,
  output logic req_ok
);
  localparam int LAST = SYNC_STAGES - 1;
  logic [LAST:0] sync_q;
  logic          hold_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= '0;
      hold_q <= 1'b0;
      req_ok <= 1'b0;
    end else begin
      sync_q <= {sync_q[LAST-1:0], req_async};
      hold_q <= sync_q[LAST];
      if (sync_q[LAST] == hold_q) req_ok <= hold_q;
    end
  end
endmodule

// File: rtl/csg_gate_cell.sv
module csg_gate_cell (
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic oe_en,
  input  logic drive_tri,
  output logic out_t,
  output logic out_c,
  output logic out_oe
);
  logic gate_q;

  // gate updates on the falling edge, i.e. only while the clock is low
  always_ff @(negedge clk) begin
    if (rst) gate_q <= 1'b1;
    else     gate_q <= run;
  end

  always_comb begin
    out_t  = clk & gate_q;
    out_c  = ~clk & gate_q;
    out_oe = oe_en & (gate_q | ~drive_tri);
  end
endmodule

// File: rtl/clk_stop_gate.sv
module clk_stop_gate #(
  parameter int N_CH        = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [N_CH-1:0] req_n,
  input  logic [N_CH-1:0] req_en,
  input  logic [N_CH-1:0] stoppable,
  input  logic [N_CH-1:0] drive_tri,
  input  logic [N_CH-1:0] oe_cfg,
  input  logic            stop_n,
  input  logic            sw_run,
  output logic [N_CH-1:0] clk_t,
  output logic [N_CH-1:0] clk_c,
  output logic [N_CH-1:0] oe
);
  import csg_pkg::*;

  logic stop_q;
  logic global_stop;

  always_ff @(posedge clk) begin
    if (rst) stop_q <= 1'b0;
    else     stop_q <= ~stop_n;
  end

  assign global_stop = stop_q | ~sw_run;

  for (genvar i = 0; i < N_CH; i++) begin : g_ch
    csg_cfg_t cfg;
    logic     req_halt;
    logic     run;

    assign cfg = '{req_en: req_en[i], stoppable: stoppable[i],
                   drive_tri: drive_tri[i], oe_en: oe_cfg[i]};

    csg_req_filter #(.SYNC_STAGES(SYNC_STAGES)) u_filt (
      .clk       (clk),
      .rst       (rst),
      .req_async (req_n[i]),
      .req_ok    (req_halt)
    );

    assign run = ~(cfg.req_en & req_halt) & ~(cfg.stoppable & global_stop);

    csg_gate_cell u_gate (
      .clk       (clk),
      .rst       (rst),
      .run       (run),
      .oe_en     (cfg.oe_en),
      .drive_tri (cfg.drive_tri),
      .out_t     (clk_t[i]),
      .out_c     (clk_c[i]),
      .out_oe    (oe[i])
    );
  end
endmodule

// File: rtl/csg_checker.sv
module csg_checker #(
  parameter int N_CH = 4
) (
  input logic            clk,
  input logic            rst,
  input logic [N_CH-1:0] req_en,
  input logic [N_CH-1:0] stoppable,
  input logic [N_CH-1:0] drive_tri,
  input logic [N_CH-1:0] oe_cfg,
  input logic [N_CH-1:0] clk_t,
  input logic [N_CH-1:0] clk_c,
  input logic [N_CH-1:0] oe
);
  for (genvar i = 0; i < N_CH; i++) begin : g_a
    // R4, R5: no request control and not stoppable -> always toggles
    p_free_run_r4: assert property (@(negedge clk) disable iff (rst)
      (!$past(req_en[i]) && !$past(stoppable[i])) |-> clk_t[i]);
    p_tri_parked_r8: assert property (@(negedge clk) disable iff (rst)
      (oe_cfg[i] && drive_tri[i] && !clk_t[i]) |-> !oe[i]);
    p_oe_off_r9: assert property (@(negedge clk) disable iff (rst)
      !oe_cfg[i] |-> !oe[i]);
    p_low_phase_r10: assert property (@(posedge clk) disable iff (rst)
      !clk_t[i]);
    always_comb begin
      if (!rst) p_legs_excl_r2: assert (!(clk_t[i] && clk_c[i]));
    end
  end
endmodule

bind clk_stop_gate csg_checker #(.N_CH(N_CH)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .req_en    (req_en),
  .stoppable (stoppable),
  .drive_tri (drive_tri),
  .oe_cfg    (oe_cfg),
  .clk_t     (clk_t),
  .clk_c     (clk_c),
  .oe        (oe)
);

// File: tb/clk_stop_gate_tb.sv
module clk_stop_gate_tb;
  localparam int PERIOD = 10;
  localparam int N = 4;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [N-1:0] req_n = '0, req_en = '0, stoppable = '0, drive_tri = '0;
  logic [N-1:0] oe_cfg = '1;
  logic         stop_n = 1'b1, sw_run = 1'b1;
  logic [N-1:0] clk_t, clk_c, oe;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #(PERIOD/2) clk = ~clk;

  clk_stop_gate #(.N_CH(N)) u_dut (
    .clk(clk), .rst(rst), .req_n(req_n), .req_en(req_en),
    .stoppable(stoppable), .drive_tri(drive_tri), .oe_cfg(oe_cfg),
    .stop_n(stop_n), .sw_run(sw_run), .clk_t(clk_t), .clk_c(clk_c), .oe(oe));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // wait to the middle of the next high phase
  task automatic hi();
    @(posedge clk); #2;
  endtask
  task automatic lo();
    @(negedge clk); #2;
  endtask
  task automatic cyc(input int n);
    for (int k = 0; k < n; k++) hi();
  endtask

  task automatic t_reset();
    rst = 1'b1; cyc(3); rst = 1'b0;
    cyc(2);
    chk(clk_t == 4'hF, "R11 true legs toggle", clk_t, 4'hF);
    chk(oe == oe_cfg, "R11 oe follows cfg", oe, oe_cfg);
    lo();
    chk(clk_c == 4'hF, "R11 complement legs toggle", clk_c, 4'hF);
  endtask

  task automatic t_filter();
    bit dropped = 0;
    req_en = 4'b0001;
    hi(); req_n[0] = 1'b1;
    hi(); req_n[0] = 1'b0;
    for (int k = 0; k < 8; k++) begin
      hi(); if (!clk_t[0]) dropped = 1;
    end
    chk(!dropped, "R1 one-period pulse rejected", dropped, 0);
  endtask

  task automatic t_stop();
    req_en = 4'b0011;
    hi(); req_n = 4'b0111;
    cyc(8);
    chk(clk_t[1:0] == 2'b00, "R2 true legs parked low", clk_t[1:0], 0);
    chk(clk_t[2] == 1'b1, "R4 disabled request ignored", clk_t[2], 1);
    chk(clk_t[3] == 1'b1, "R2 other channel runs", clk_t[3], 1);
    lo();
    chk(clk_c[1:0] == 2'b00, "R2 complement legs parked low", clk_c[1:0], 0);
  endtask

  task automatic t_resume();
    int k0 = 0, k1 = 0;
    hi(); req_n = 4'b0000;
    for (int k = 1; k <= 8; k++) begin
      hi();
      if (clk_t[0] && k0 == 0) k0 = k;
      if (clk_t[1] && k1 == 0) k1 = k;
    end
    chk(k0 >= 2 && k0 <= 6, "R3 resume latency", k0, 5);
    chk(k0 == k1, "R3 channels resume together", k1, k0);
    req_en = '0;
  endtask

  task automatic t_gstop();
    int k0 = 0, k2 = 0;
    stoppable = 4'b0101;
    hi(); stop_n = 1'b0;
    cyc(3);
    chk(clk_t == 4'b1010, "R5 stoppable halted, others run", clk_t, 4'b1010);
    stop_n = 1'b1;
    for (int k = 1; k <= 4; k++) begin
      hi();
      if (clk_t[0] && k0 == 0) k0 = k;
      if (clk_t[2] && k2 == 0) k2 = k;
    end
    chk(k0 >= 1 && k0 <= 2, "R6 restart within two periods", k0, 2);
    chk(k0 == k2, "R6 synchronous restart", k2, k0);
  endtask

  task automatic t_sw();
    hi(); sw_run = 1'b0;
    cyc(2);
    chk(clk_t == 4'b1010, "R7 software stop halts", clk_t, 4'b1010);
    sw_run = 1'b1;
    cyc(2);
    chk(clk_t == 4'hF, "R7 software resume", clk_t, 4'hF);
  endtask

  task automatic t_drive();
    stoppable = 4'b0011; drive_tri = 4'b0001;
    hi(); stop_n = 1'b0;
    cyc(3);
    chk(clk_t == 4'b1100, "R8 both channels halted", clk_t, 4'b1100);
    chk(oe == 4'b1110, "R8 tri-state vs driven when halted", oe, 4'b1110);
    stop_n = 1'b1;
    cyc(3);
    chk(oe == 4'hF, "R8 oe back after resume", oe, 4'hF);
    drive_tri = '0;
  endtask

  task automatic t_oe();
    hi(); #1 oe_cfg[3] = 1'b0;
    #0 chk(oe[3] == 1'b0, "R9 oe off at once", oe[3], 0);
    hi();
    chk(oe[3] == 1'b0 && clk_t[3], "R9 oe off while running", oe[3], 0);
    oe_cfg[3] = 1'b1;
  endtask

  task automatic t_runt();
    int bad = 0;
    stoppable = 4'hF;
    hi(); sw_run = 1'b0;
    for (int k = 0; k < 4; k++) begin lo(); if (clk_t != 0) bad++; end
    sw_run = 1'b1;
    for (int k = 0; k < 4; k++) begin lo(); if (clk_t != 0) bad++; end
    chk(bad == 0, "R10 true leg low in low phase", bad, 0);
    stoppable = '0;
  endtask

  initial begin
    t_reset();
    t_filter();
    t_stop();
    t_resume();
    t_gstop();
    t_sw();
    t_drive();
    t_oe();
    t_runt();
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(PERIOD * 20000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule